// File: doc/BRIEF.md
# Bidirectional Serial/Parallel Bus Register

This block is a bank of storage stages placed between two parallel buses, called side A and side B, with one extra serial data input. A small set of mode inputs picks what happens on each clock. A word can be taken from either bus and presented on the other. Serial bits can be shifted in and the assembled word shown on either bus. The stored word can be held by feeding each stage back into itself. Each bus is split into an input vector, an output vector and an output-enable, so the tri-state resolution happens outside the block.

Parallel loading has two variants. In the clocked variant the stages take the selected bus on a rising edge. In the transparent variant the outputs follow the selected bus at once, with no clock. The stages also capture that value on each edge, so it is kept once the transparent load is switched off. The direction input selects the source bus. The side-A enable gates every A-side transfer: it blocks A-side reception, and it turns off the A drivers. Serial shifting is always clocked, whatever the transparent-select input says.

A two-state controller sequences the block. `ST_INIT` is entered on reset. It holds the stages and keeps both drivers off. The transition `T_SETTLE` always moves it to `ST_RUN` on the next edge. `ST_RUN` loops on itself (`T_STAY`) until reset returns it to `ST_INIT` (`T_RESET`). Within `ST_RUN` the controller decodes one of these operations: `OP_SHIFT`, `OP_LOAD_SYNC` or `OP_LOAD_ASYNC`. `OP_HOLD` is used only in `ST_INIT`.

Top module: `busreg_bidir`

## Requirements
- R1: While `rst_n` is low on a rising edge, all stages clear to 0 and both enables go low. On the first rising edge after release, no stage changes. Both enables stay low until that edge has passed.
- R2: With `load_par`=1, `load_async`=0, `dir_a2b`=1 and `a_side_en`=1, a rising edge copies `a_in` into the stages. `b_out` then shows that word.
- R3: With `load_par`=1, `load_async`=0, `dir_a2b`=0 and `a_side_en`=1, a rising edge copies `b_in` into the stages. `a_out` then shows that word.
- R4: With `load_par`=1, `dir_a2b`=1 and `a_side_en`=0, every stage reloads itself, so `a_in` has no effect. The contents stay unchanged on `b_out`, in both the clocked and the transparent variant.
- R5: With `load_par`=1, `dir_a2b`=0 and `a_side_en`=0, `b_in` is still loaded, but `a_oe` stays low.
- R6: With `load_par`=1 and `load_async`=1, both data outputs show the selected source word in the same cycle, before any clock edge.
- R7: A word loaded while `load_async`=1 is held in the stages across a rising edge. It is still shown after `load_async` drops to 0.
- R8: With `load_par`=0, a rising edge shifts the word one place: `ser_in` enters bit 0 and bit i moves to bit i+1. `load_async` has no effect, and the outputs show only the stored word.
- R9: `ser_out` always equals the stored bit `WIDTH-1`, the last stage.
- R10: After the settle cycle, in every mode, `b_oe` equals `dir_a2b`, and `a_oe` equals (NOT `dir_a2b`) AND `a_side_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_side_en | input | 1 | Gate for side-A transfers in both directions |
| load_async | input | 1 | 1 = transparent parallel load, 0 = clocked |
| dir_a2b | input | 1 | 1 = A is source and B is driven, 0 = reverse |
| load_par | input | 1 | 1 = parallel load, 0 = serial shift |
| ser_in | input | 1 | Serial data into stage 0 |
| a_in | input | WIDTH | Side-A bus as received |
| b_in | input | WIDTH | Side-B bus as received |
| a_out | output | WIDTH | Word presented toward side A |
| a_oe | output | 1 | Drive enable for side A |
| b_out | output | WIDTH | Word presented toward side B |
| b_oe | output | 1 | Drive enable for side B |
| ser_out | output | 1 | Last stage, for chaining |

## Verification
The clocked load is swept through all 256 words in both directions. A miswired bit or a swapped source bus therefore shows up on some value, and `ser_out` is compared against the top bit of each word. A second sweep covers all 16 combinations of the four mode inputs, each with four data and serial-bit patterns. It separates reload from load, shows that a disabled side A ignores `a_in`, and confirms that the transparent select has no effect while shifting. The output is checked both before and after each edge, which separates the transparent path from the clocked one. A dedicated sequence drops the transparent select after a load to show that the word is kept.

// File: rtl/busreg_pkg.sv
package busreg_pkg;
    typedef enum logic {
        ST_INIT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_SHIFT,
        OP_LOAD_SYNC,
        OP_LOAD_ASYNC
    } op_t;

    typedef enum logic [1:0] {
        SRC_SELF,
        SRC_A,
        SRC_B
    } src_t;
endpackage

// File: rtl/busreg_ctrl.sv
module busreg_ctrl
    import busreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_side_en,
    input  logic load_async,
    input  logic dir_a2b,
    input  logic load_par,
    output op_t  op,
    output src_t src,
    output logic a_oe,
    output logic b_oe
);
    run_state_t state_q, state_d;

    // Transitions: T_SETTLE (INIT->RUN), T_STAY (RUN->RUN), T_RESET (any->INIT)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    always_comb begin
        src  = dir_a2b ? (a_side_en ? SRC_A : SRC_SELF) : SRC_B;
        op   = OP_HOLD;
        a_oe = 1'b0;
        b_oe = 1'b0;
        unique case (state_q)
            ST_INIT: ;
            ST_RUN: begin
                if (!load_par)       op = OP_SHIFT;
                else if (load_async) op = OP_LOAD_ASYNC;
                else                 op = OP_LOAD_SYNC;
                b_oe = dir_a2b;
                a_oe = !dir_a2b && a_side_en;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/busreg_stages.sv
module busreg_stages
    import busreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_t              op,
    input  src_t             src,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] view,
    output logic             ser_out
);
    localparam int LAST = WIDTH - 1;

    logic [LAST:0] stage_q;
    logic [LAST:0] stage_d;
    logic [LAST:0] load_word;

    always_comb begin
        unique case (src)
            SRC_A:   load_word = a_in;
            SRC_B:   load_word = b_in;
            default: load_word = stage_q;
        endcase
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic shift_src;
        if (i == 0) begin : g_head
            assign shift_src = ser_in;
        end else begin : g_link
            assign shift_src = stage_q[i-1];
        end
        assign stage_d[i] = (op == OP_SHIFT) ? shift_src :
                            (op == OP_HOLD)  ? stage_q[i] : load_word[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    // Transparent load shows the source now; the flops still capture it.
    assign view    = (op == OP_LOAD_ASYNC) ? load_word : stage_q;
    assign ser_out = stage_q[LAST];
endmodule

// File: rtl/busreg_bidir.sv
module busreg_bidir
    import busreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_side_en,
    input  logic             load_async,
    input  logic             dir_a2b,
    input  logic             load_par,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    output logic             ser_out
);
    op_t              op;
    src_t             src;
    logic [WIDTH-1:0] view;

    busreg_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .a_side_en  (a_side_en),
        .load_async (load_async),
        .dir_a2b    (dir_a2b),
        .load_par   (load_par),
        .op         (op),
        .src        (src),
        .a_oe       (a_oe),
        .b_oe       (b_oe)
    );

    busreg_stages #(.WIDTH(WIDTH)) u_stages (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .src     (src),
        .ser_in  (ser_in),
        .a_in    (a_in),
        .b_in    (b_in),
        .view    (view),
        .ser_out (ser_out)
    );

    assign a_out = view;
    assign b_out = view;
endmodule

// File: rtl/busreg_bidir_chk.sv
module busreg_bidir_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a_side_en,
    input logic             load_async,
    input logic             dir_a2b,
    input logic             load_par,
    input logic             ser_in,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic             ser_out
);
    logic transp;
    assign transp = load_par && load_async;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (b_out == '0 && !a_oe && !b_oe)); // R1

    AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_par && !load_async && dir_a2b && a_side_en && b_oe)
        |=> (transp || b_out == $past(a_in))); // R2

    AST_RECIRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_par && !load_async && dir_a2b && !a_side_en && b_oe)
        |=> (transp || b_out == $past(b_out))); // R4

    AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
        (transp && dir_a2b && a_side_en && b_oe) |-> (b_out == a_in)); // R6

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_par && b_oe)
        |=> (transp || b_out == {$past(b_out[WIDTH-2:0]), $past(ser_in)})); // R8

    AST_TAIL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!transp) |-> (ser_out == b_out[WIDTH-1])); // R9

    AST_A_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe |-> (!dir_a2b && a_side_en && !b_oe)); // R10
endmodule

bind busreg_bidir busreg_bidir_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_side_en  (a_side_en),
    .load_async (load_async),
    .dir_a2b    (dir_a2b),
    .load_par   (load_par),
    .ser_in     (ser_in),
    .a_in       (a_in),
    .b_in       (b_in),
    .a_out      (a_out),
    .a_oe       (a_oe),
    .b_out      (b_out),
    .b_oe       (b_oe),
    .ser_out    (ser_out)
);

// File: tb/sim_busreg_bidir.sv
`timescale 1ns/1ps
module sim_busreg_bidir;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         a_side_en, load_async, dir_a2b, load_par, ser_in;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, ser_out;

    int           n_cmp = 0;
    int           n_bad = 0;
    logic [W-1:0] mq;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    busreg_bidir #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .a_side_en(a_side_en), .load_async(load_async),
        .dir_a2b(dir_a2b), .load_par(load_par), .ser_in(ser_in),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
        .b_out(b_out), .b_oe(b_oe), .ser_out(ser_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic string load_tag();
        if (!load_par) return "R8 shift";
        if (dir_a2b)   return a_side_en ? "R2 load A" : "R4 recirculate";
        return a_side_en ? "R3 load B" : "R5 load B, A off";
    endfunction

    // Called at a falling edge with inputs already set.
    task automatic step(input string tag);
        logic [W-1:0] src, nxt;
        #1;
        src = dir_a2b ? (a_side_en ? a_in : mq) : b_in;
        if (load_par && load_async)
            chk("R6 transparent before edge", 32'(b_out), 32'(src));
        else
            chk({tag, " before edge"}, 32'(b_out), 32'(mq));
        nxt = load_par ? src : {mq[W-2:0], ser_in};
        @(posedge clk);
        mq = nxt;
        @(negedge clk);
        chk({tag, " b_out"}, 32'(b_out), 32'(mq));
        chk({tag, " a_out"}, 32'(a_out), 32'(mq));
        chk("R9 ser_out", 32'(ser_out), 32'(mq[W-1]));
        chk("R10 b_oe", 32'(b_oe), 32'(dir_a2b));
        chk("R10 a_oe", 32'(a_oe), 32'(!dir_a2b && a_side_en));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        a_side_en = 1'b1; load_async = 1'b0; dir_a2b = 1'b1; load_par = 1'b1;
        ser_in = 1'b1; a_in = 8'hA5; b_in = 8'h5A;
        repeat (3) @(negedge clk);
        chk("R1 reset clears", 32'(b_out), 32'h0);
        chk("R1 reset b_oe", 32'(b_oe), 32'h0);
        chk("R1 reset a_oe", 32'(a_oe), 32'h0);
        chk("R1 reset ser_out", 32'(ser_out), 32'h0);
        rst_n = 1'b1;
        #1;
        chk("R1 b_oe low in settle", 32'(b_oe), 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R1 settle edge holds", 32'(b_out), 32'h0);
        chk("R10 b_oe after settle", 32'(b_oe), 32'h1);
        mq = '0;

        // Clocked load, every word, both directions
        for (int v = 0; v < 256; v++) begin
            load_par = 1'b1; load_async = 1'b0; a_side_en = 1'b1;
            dir_a2b = 1'b1; a_in = 8'(v); b_in = 8'(~v);
            step("R2 load A");
            dir_a2b = 1'b0; b_in = 8'(v ^ 8'h96); a_in = 8'(~v);
            step("R3 load B");
        end

        // All mode combinations with several data patterns
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 4; p++) begin
                a_side_en  = c[0];
                load_par   = c[1];
                dir_a2b    = c[2];
                load_async = c[3];
                a_in   = 8'((8'h5A ^ (p * 8'h33)) + c);
                b_in   = 8'((8'hC3 ^ (p * 8'h1D)) - c);
                ser_in = p[0] ^ c[0];
                step(load_tag());
            end
        end

        // Transparent load is retained after the select drops
        load_par = 1'b1; load_async = 1'b1; dir_a2b = 1'b0; a_side_en = 1'b1;
        b_in = 8'h3C; a_in = 8'h00;
        step("R7 transparent load");
        load_async = 1'b0; dir_a2b = 1'b1; a_side_en = 1'b0; b_in = 8'hFF; a_in = 8'hFF;
        #1;
        chk("R7 retained after select drops", 32'(b_out), 32'h3C);
        step("R4 recirculate");
        chk("R7 still retained", 32'(b_out), 32'h3C);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule